// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port that sits behind a plain memory-mapped register bus with byte-wide reads and writes. Each pin can be an input or an output. A direction register sets the mode of each pin. An output data register holds the level that is driven on output pins. The port drives a pad output value and a pad output-enable. Pad inputs pass through a two-flop synchronizer before any other logic uses them.

The data register does not sit at one address. It is reached through a window of 256 word-aligned addresses, and address bits [9:2] form a per-pin mask. A write changes only the pins selected by the mask. A read returns only the selected pins and gives zero for the rest. Software can therefore set, clear or test a single pin with one bus access and no read-modify-write sequence. This also means that two agents working on different pins cannot overwrite each other's pins.

A bus access lasts one cycle with `sel_i` high. Writes take effect at that clock edge. Read data is registered at that same edge and appears on `rdata_o` in the following cycle. `rdata_o` then keeps its value until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, every pin is an input, the output data register is 0, `pad_oe_o` and `pad_o` are 0, and `rdata_o` is 0.
- R2: A write to offset 0x400 loads the direction register. A 1 bit makes that pin an output and a 0 bit makes it an input. `pad_oe_o` follows the direction register, and a read of 0x400 returns it.
- R3: Data accesses use word-aligned offsets 0x000 to 0x3FC, meaning address bits [11:10] and [1:0] are zero. Pin n is selected when address bit n+2 is 1, so pin n alone is at 1<<(n+2). On a data write, only the selected output pins take bit n of `wdata_i`. Every other bit of the output data register keeps its value.
- R4: A data write has no effect on the output data bit of any pin that is currently an input. When that pin later becomes an output, it drives its earlier value.
- R5: On a data read, each bit whose address mask bit is 0 returns 0.
- R6: On a data read, each selected output pin returns its driven output value, and each selected input pin returns its synchronized pad value.
- R7: A change on `pad_i` reaches the read path through exactly two flops. A data read issued in the cycle of the change returns the old value, and so does a read one cycle later. A read two cycles after the change returns the new value.
- R8: A read of an unmapped offset returns 0. A write to an unmapped offset changes neither register.
- R9: `rdata_o` updates one cycle after a read access and holds its value in every other cycle. Reads never change the pad outputs.

Bus encoding: `sel_i`=1 with `wr_i`=1 is a write, and `sel_i`=1 with `wr_i`=0 is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe for one cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pad_i | input | 8 | Pad input levels (asynchronous) |
| pad_o | output | 8 | Pad output levels |
| pad_oe_o | output | 8 | Pad output enables, 1 = drive |

## Verification
The bench builds the block with its default parameters: eight pins, a 12-bit offset, the mask starting at address bit 2, and the direction register at 0x400. With these values every one of the 256 mask patterns can be reached. Both register offsets fall inside the tested range, and so do unmapped offsets above the window and misaligned offsets inside it. The random stimulus mixes direction changes with masked writes and reads. This covers input and output pins under partial masks, writes to pins that are inputs, and reads of pins whose pad value differs from their output value.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] sync_o
);
  logic [NUM_PINS-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // cycles since reset, saturating, for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sync_o == $past(pad_i, 2))); // R7
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dir_we_i,
  input  logic                data_we_i,
  input  logic [NUM_PINS-1:0] wmask_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] out_o
);
  logic [NUM_PINS-1:0] dir_q, out_q, upd;

  // only pins that are selected and currently outputs take new data
  assign upd = wmask_i & dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_we_i)  dir_q <= wdata_i;
      if (data_we_i) out_q <= (out_q & ~upd) | (wdata_i & upd);
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;

  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_we_i |=> $stable(dir_o)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_we_i |=> $stable(out_o)); // R3
  AST_UNSELECTED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> (((out_o ^ $past(out_o)) & ~$past(wmask_i)) == '0)); // R3
  AST_INPUT_PIN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> (((out_o ^ $past(out_o)) & ~$past(dir_o)) == '0)); // R4
endmodule

// File: rtl/gpio_rdpath.sv
module gpio_rdpath
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  acc_kind_e           kind_i,
  input  logic [NUM_PINS-1:0] rmask_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] sync_i,
  output logic [NUM_PINS-1:0] rdata_o
);
  logic [NUM_PINS-1:0] pin_val, rd_mux, rdata_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_val[p] = rmask_i[p] & (dir_i[p] ? out_i[p] : sync_i[p]);
  end

  always_comb begin
    unique case (kind_i)
      ACC_DATA: rd_mux = pin_val;
      ACC_DIR:  rd_mux = dir_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && kind_i == ACC_NONE) |=> (rdata_o == '0)); // R8
  AST_MASKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && kind_i == ACC_DATA) |=> ((rdata_o & ~$past(rmask_i)) == '0)); // R5
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned MASK_LSB   = 2,
  parameter int unsigned DIR_OFFSET = 'h400
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  localparam int unsigned WIN_BITS = MASK_LSB + NUM_PINS;

  acc_kind_e           kind;
  logic                data_hit, dir_hit;
  logic [NUM_PINS-1:0] amask, dir, outv, sync;

  assign data_hit = (addr_i[ADDR_W-1:WIN_BITS] == '0) && (addr_i[MASK_LSB-1:0] == '0);
  assign dir_hit  = (addr_i == ADDR_W'(DIR_OFFSET));
  assign amask    = addr_i[MASK_LSB +: NUM_PINS];

  always_comb begin
    if (data_hit)     kind = ACC_DATA;
    else if (dir_hit) kind = ACC_DIR;
    else              kind = ACC_NONE;
  end

  gpio_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_i),
    .sync_o (sync)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dir_we_i  (sel_i && wr_i && kind == ACC_DIR),
    .data_we_i (sel_i && wr_i && kind == ACC_DATA),
    .wmask_i   (amask),
    .wdata_i   (wdata_i),
    .dir_o     (dir),
    .out_o     (outv)
  );

  gpio_rdpath #(.NUM_PINS(NUM_PINS)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (sel_i && !wr_i),
    .kind_i  (kind),
    .rmask_i (amask),
    .dir_i   (dir),
    .out_i   (outv),
    .sync_i  (sync),
    .rdata_o (rdata_o)
  );

  assign pad_o    = outv;
  assign pad_oe_o = dir;

  AST_READ_NO_SIDE_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i) |=> ($stable(pad_o) && $stable(pad_oe_o))); // R9
  AST_UNMAPPED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && !data_hit && !dir_hit) |=> ($stable(pad_o) && $stable(pad_oe_o))); // R8
endmodule

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  logic [7:0] dir_m = '0, out_m = '0;

  always #2 clk = ~clk;

  gpio_mask_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic bit is_data(logic [11:0] a);
    return (a[11:10] == 2'b00) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] exp_read(logic [11:0] a);
    if (is_data(a)) return a[9:2] & ((dir_m & out_m) | (~dir_m & pad_in));
    if (a == 12'h400) return dir_m;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic bus_wr(logic [11:0] a, logic [7:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    if (is_data(a)) out_m = (out_m & ~(a[9:2] & dir_m)) | (d & a[9:2] & dir_m);
    else if (a == 12'h400) dir_m = d;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [7:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic chk_pads(string req);
    chk({req, " pad_o"}, pad_out, out_m);
    chk({req, " pad_oe_o"}, pad_oe, dir_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, e, keep;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk_pads("R1");
    bus_rd(12'h400, r); chk("R1 dir", r, 8'h00);

    // R2 direction write and readback
    bus_wr(12'h400, 8'hA5); chk_pads("R2");
    bus_rd(12'h400, r); chk("R2 readback", r, 8'hA5);

    // R3 single-pin writes, other pins kept
    bus_wr(12'h400, 8'hFF);
    bus_wr(12'h3FC, 8'h00);
    bus_wr(12'h004, 8'hFF);              // pin 0 only
    chk("R3 pin0", pad_out, 8'h01);
    bus_wr(12'h200, 8'hFF);              // pin 7 only
    chk("R3 pin7", pad_out, 8'h81);
    bus_wr(12'h000, 8'h00);              // empty mask
    chk("R3 empty mask", pad_out, 8'h81);
    bus_wr(12'h3FC, 8'h3C);
    chk("R3 full mask", pad_out, 8'h3C);

    // R4 write to input pins is dropped, shows once pin is output
    bus_wr(12'h400, 8'h0F);
    bus_wr(12'h3FC, 8'hC3);
    chk("R4 input keep", pad_out, 8'h33);
    bus_wr(12'h400, 8'hFF);
    chk("R4 later drive", pad_out, 8'h33);

    // R5/R6 masked read mixing inputs and outputs
    bus_wr(12'h400, 8'hF0);
    pad_in = 8'h5A;
    @(negedge clk); @(negedge clk);
    bus_rd(12'h3FC, r); chk("R6 full read", r, 8'h3A);
    bus_rd(12'h0F0, r); chk("R5 partial read", r, 8'h3A & 8'h3C);
    bus_rd(12'h000, r); chk("R5 empty read", r, 8'h00);

    // R7 synchronizer latency on input pin 0
    bus_wr(12'h400, 8'h00);
    pad_in = 8'h00;
    @(negedge clk); @(negedge clk);
    pad_in = 8'h01;
    bus_rd(12'h004, r); chk("R7 same cycle", r, 8'h00);
    bus_rd(12'h004, r); chk("R7 one later", r, 8'h00);
    bus_rd(12'h004, r); chk("R7 two later", r, 8'h01);

    // R8 unmapped offsets
    bus_wr(12'h400, 8'h55);
    keep = pad_out;
    bus_wr(12'h404, 8'hFF); chk("R8 wr 404 dir", pad_oe, 8'h55);
    bus_wr(12'h006, 8'hFF); chk("R8 misaligned wr", pad_out, keep);
    bus_wr(12'hC04, 8'hAA); chk("R8 high wr", pad_out, keep);
    bus_rd(12'h401, r); chk("R8 rd 401", r, 8'h00);
    bus_rd(12'h802, r); chk("R8 rd 802", r, 8'h00);

    // R9 hold between reads
    bus_rd(12'h400, r);
    repeat (3) @(negedge clk);
    chk("R9 hold", rdata, 8'h55);
    bus_wr(12'h3FC, 8'h00);
    chk("R9 hold across write", rdata, 8'h55);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [11:0] a;
      case (op)
        0, 1: begin
          a = {2'b00, 8'($urandom), 2'b00};
          bus_wr(a, 8'($urandom)); chk_pads("R3/R4 rand wr");
        end
        2: begin
          bus_wr(12'h400, 8'($urandom)); chk_pads("R2 rand dir");
        end
        3, 4, 5: begin
          a = {2'b00, 8'($urandom), 2'b00};
          e = exp_read(a);
          bus_rd(a, r); chk("R5/R6 rand rd", r, e);
        end
        6: begin
          bus_rd(12'h400, r); chk("R2 rand dir rd", r, dir_m);
        end
        7: begin
          a = 12'($urandom);
          if (is_data(a) || a == 12'h400) a = a | 12'h001;
          if ($urandom_range(0, 1) == 0) begin
            bus_wr(a, 8'($urandom)); chk_pads("R8 rand unmapped wr");
          end else begin
            bus_rd(a, r); chk("R8 rand unmapped rd", r, 8'h00);
          end
        end
        default: begin
          pad_in = 8'($urandom);
          @(negedge clk); @(negedge clk);
        end
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule